// File: doc/BRIEF.md
# Windowed and Banked Address Translator

This block sits between a 16-bit processor and a wider physical memory system. Each cycle it takes the processor address and produces a 20-bit physical address, a region code saying which kind of target is addressed, and a flag that tells the downstream fixed decoder to handle the access itself. The fixed decoder and the memory arrays are outside the block.

Three mappings are layered. When it is enabled, a 1 KB window at 0x7C00–0x7FFF is relocated by an 8-bit offset into physical page 0. Otherwise, when banking is enabled and the address is below 0xFC00, one of sixteen 8-bit bank registers replaces the top address nibble. Everything else passes unchanged to the fixed map. Some bank values have special meanings. Values 0x30–0x3F send the access back into the standard 64 KB map. Offsets 0xD80–0xD97 under bank 0x3F form a null hole, because that is where the bank registers themselves sit. A bank value that points past the installed extended-RAM pages also selects the null region, which downstream logic reads as 0xFF and which ignores writes.

The outputs are registered, so each translation appears one clock after its address. A bank-register write becomes visible to the translation in the following cycle.

Top module: `addr_xlat`

## Requirements
- R1: With `win_en` high and `cpu_addr` in 0x7C00–0x7FFF, the result is region 1 (window) with `phys_addr` = {4'h0, (`win_ofs`·256 + `cpu_addr`) mod 65536} and `to_fixed` low.
- R2: A window hit takes precedence over bank translation, even when `bank_en` is high.
- R3: The bank register is chosen by `cpu_addr[15:12]`. `cpu_addr[11:0]` becomes `phys_addr[11:0]` in every banked result that is not null.
- R4: With `bank_en` high, an address of 0xFC00 or above that is not a window hit is never banked. It yields region 0 (fixed) with `phys_addr` = {4'h0, `cpu_addr`} and `to_fixed` high.
- R5: A bank value of 0x30–0x3E yields region 0 with `phys_addr` = {4'h0, bank[3:0], offset} and `to_fixed` high.
- R6: A bank value of 0x3F with offset 0xD80–0xD97 yields region 4 (null), `phys_addr` 0 and `to_fixed` low.
- R7: A bank value of 0x3F with any other offset yields region 0 with `phys_addr` = {4'h0, 4'hF, offset} and `to_fixed` high.
- R8: A bank value of 0x00–0x2F yields region 2 (low page) with `phys_addr` = {bank, offset}.
- R9: A bank value of 0x40 or above whose page bank[7:4] is below 4 + `ext_pages` yields region 3 (extended RAM) with `phys_addr` = {bank, offset}.
- R10: A bank value of 0x40 or above whose page is at or beyond 4 + `ext_pages` yields region 4, `phys_addr` 0 and `to_fixed` low.
- R11: During reset the outputs hold region 4, `phys_addr` 0 and `to_fixed` low. After reset, bank register i holds 0x30 + i, so banked accesses map to themselves.
- R12: With both `win_en` and `bank_en` low, every address yields region 0 with `phys_addr` = {4'h0, `cpu_addr`} and `to_fixed` high.
- R13: The outputs reflect the inputs sampled at the previous rising clock edge. A bank write at an edge does not affect the translation registered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Processor address to translate |
| win_en | input | 1 | Enables the relocatable window |
| win_ofs | input | 8 | Window offset, added as offset·256 |
| bank_en | input | 1 | Enables bank translation |
| bank_we | input | 1 | Bank register write strobe |
| bank_widx | input | 4 | Bank register index to write |
| bank_wdata | input | 8 | Bank value to write |
| ext_pages | input | 4 | Installed extended-RAM page count |
| phys_addr | output | 20 | Translated physical address |
| region | output | 3 | Region code: 0 fixed, 1 window, 2 low page, 3 extended RAM, 4 null |
| to_fixed | output | 1 | High when the fixed decoder must handle the access |

## Verification
Each translated result is due exactly one clock after the address and control inputs are presented. A bank write made at an edge is first visible in the result registered one edge later. The bench drives inputs on the falling edge and reads outputs on the falling edge after the next rising edge. It computes each expected value from the bank contents as they stood before that step's write, and only afterwards applies the write to its model. Reset values are read while reset is still held, and stimulus starts only after the two-stage reset release has completed.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
  typedef enum logic [2:0] {
    RGN_FIXED   = 3'd0,
    RGN_WINDOW  = 3'd1,
    RGN_LOWPAGE = 3'd2,
    RGN_EXTRAM  = 3'd3,
    RGN_NULL    = 3'd4
  } region_e;
endpackage

// File: rtl/xlat_bank_file.sv
module xlat_bank_file #(
  parameter int IDX_W      = 4,
  parameter int BANK_W     = 8,
  parameter int IDENT_BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BANK_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BANK_W-1:0] rdata
);
  localparam int NUM = 1 << IDX_W;

  logic [BANK_W-1:0] bank_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_entry
    logic              sel;
    logic [BANK_W-1:0] bank_d;

    always_comb begin
      sel    = we && (widx == IDX_W'(i));
      bank_d = bank_q[i];
      if (sel) bank_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[i] <= BANK_W'(IDENT_BASE + i);
      else if (sel) bank_q[i] <= bank_d;
    end
  end

  assign rdata = bank_q[ridx];
endmodule

// File: rtl/xlat_window.sv
module xlat_window #(
  parameter int ADDR_W   = 16,
  parameter int WOFS_W   = 8,
  parameter int PHYS_W   = 20,
  parameter int WIN_BASE = 16'h7C00,
  parameter int WIN_SIZE = 1024
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WOFS_W-1:0] ofs,
  output logic              hit,
  output logic [PHYS_W-1:0] phys
);
  localparam int SHIFT    = ADDR_W - WOFS_W;
  localparam int WIN_LAST = WIN_BASE + WIN_SIZE - 1;

  logic [ADDR_W-1:0] sum;

  always_comb begin
    hit  = en && (addr >= ADDR_W'(WIN_BASE)) && (addr <= ADDR_W'(WIN_LAST));
    sum  = {ofs, {SHIFT{1'b0}}} + addr;
    phys = {{(PHYS_W-ADDR_W){1'b0}}, sum};
  end
endmodule

// File: rtl/xlat_bank_map.sv
module xlat_bank_map
  import addr_xlat_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 4,
  parameter int BANK_W    = 8,
  parameter int EXTP_W    = 4,
  parameter int BANK_CEIL = 16'hFC00,
  parameter int STD_PAGE  = 3,
  parameter int EXT_BASE  = 4,
  parameter int HOLE_LO   = 12'hD80,
  parameter int HOLE_HI   = 12'hD97
) (
  input  logic                     en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BANK_W-1:0]        bank,
  input  logic [EXTP_W-1:0]        ext_pages,
  output logic                     hit,
  output region_e                  rgn,
  output logic [BANK_W+ADDR_W-IDX_W-1:0] phys,
  output logic                     to_fixed
);
  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int PHYS_W = BANK_W + OFS_W;
  localparam int SUB_W  = IDX_W;
  localparam int PG_W   = BANK_W - SUB_W;
  localparam int TOP_SUB = (1 << SUB_W) - 1;

  logic [OFS_W-1:0] ofs;
  logic [PG_W-1:0]  page;
  logic [SUB_W-1:0] sub;
  logic             in_hole;
  logic             ext_ok;

  always_comb begin
    ofs     = addr[OFS_W-1:0];
    page    = bank[BANK_W-1:SUB_W];
    sub     = bank[SUB_W-1:0];
    in_hole = (ofs >= OFS_W'(HOLE_LO)) && (ofs <= OFS_W'(HOLE_HI));
    ext_ok  = int'(page) < (EXT_BASE + int'(ext_pages));

    hit      = en && (addr < ADDR_W'(BANK_CEIL));
    rgn      = RGN_NULL;
    phys     = '0;
    to_fixed = 1'b0;

    if (int'(page) < STD_PAGE) begin
      rgn  = RGN_LOWPAGE;
      phys = {bank, ofs};
    end else if (int'(page) == STD_PAGE) begin
      if (!((sub == SUB_W'(TOP_SUB)) && in_hole)) begin
        rgn      = RGN_FIXED;
        phys     = {{(PHYS_W-ADDR_W){1'b0}}, sub, ofs};
        to_fixed = 1'b1;
      end
    end else if (ext_ok) begin
      rgn  = RGN_EXTRAM;
      phys = {bank, ofs};
    end
  end
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
  import addr_xlat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int BANK_W = 8,
  parameter int WOFS_W = 8,
  parameter int EXTP_W = 4,
  parameter int PHYS_W = BANK_W + ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              win_en,
  input  logic [WOFS_W-1:0] win_ofs,
  input  logic              bank_en,
  input  logic              bank_we,
  input  logic [IDX_W-1:0]  bank_widx,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic [EXTP_W-1:0] ext_pages,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [2:0]        region,
  output logic              to_fixed
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [BANK_W-1:0] cur_bank;
  logic              win_hit;
  logic [PHYS_W-1:0] win_phys;
  logic              bk_hit;
  region_e           bk_rgn;
  logic [PHYS_W-1:0] bk_phys;
  logic              bk_fixed;

  xlat_bank_file #(.IDX_W(IDX_W), .BANK_W(BANK_W), .IDENT_BASE(8'h30)) u_banks (
    .clk(clk), .rst_n(rst_sync_n), .we(bank_we), .widx(bank_widx),
    .wdata(bank_wdata), .ridx(cpu_addr[ADDR_W-1:ADDR_W-IDX_W]), .rdata(cur_bank)
  );

  xlat_window #(.ADDR_W(ADDR_W), .WOFS_W(WOFS_W), .PHYS_W(PHYS_W)) u_win (
    .en(win_en), .addr(cpu_addr), .ofs(win_ofs), .hit(win_hit), .phys(win_phys)
  );

  xlat_bank_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W), .EXTP_W(EXTP_W)) u_map (
    .en(bank_en), .addr(cpu_addr), .bank(cur_bank), .ext_pages(ext_pages),
    .hit(bk_hit), .rgn(bk_rgn), .phys(bk_phys), .to_fixed(bk_fixed)
  );

  logic [PHYS_W-1:0] phys_d, phys_q;
  region_e           rgn_d, rgn_q;
  logic              fix_d, fix_q;

  always_comb begin
    if (win_hit) begin
      phys_d = win_phys;
      rgn_d  = RGN_WINDOW;
      fix_d  = 1'b0;
    end else if (bk_hit) begin
      phys_d = bk_phys;
      rgn_d  = bk_rgn;
      fix_d  = bk_fixed;
    end else begin
      phys_d = {{(PHYS_W-ADDR_W){1'b0}}, cpu_addr};
      rgn_d  = RGN_FIXED;
      fix_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phys_q <= '0;
      rgn_q  <= RGN_NULL;
      fix_q  <= 1'b0;
    end else begin
      phys_q <= phys_d;
      rgn_q  <= rgn_d;
      fix_q  <= fix_d;
    end
  end

  assign phys_addr = phys_q;
  assign region    = rgn_q;
  assign to_fixed  = fix_q;
endmodule

// File: rtl/addr_xlat_checker.sv
module addr_xlat_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        win_en,
  input logic [7:0]  win_ofs,
  input logic        bank_en,
  input logic [19:0] phys_addr,
  input logic [2:0]  region,
  input logic        to_fixed
);
  logic        in_win;
  logic [19:0] win_exp;

  always_comb begin
    in_win  = (cpu_addr >= 16'h7C00) && (cpu_addr <= 16'h7FFF);
    win_exp = {4'h0, 16'({win_ofs, 8'h00} + cpu_addr)};
  end

  AST_WINDOW_RELOC: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && in_win) |=> (phys_addr == $past(win_exp)) && !to_fixed) // R1
    else $error("window relocation wrong");

  AST_WINDOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && bank_en && in_win) |=> (region == 3'd1)) // R2
    else $error("window lost priority");

  AST_HIGH_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en && !(win_en && in_win) && cpu_addr >= 16'hFC00)
      |=> to_fixed && region == 3'd0 && phys_addr == {4'h0, $past(cpu_addr)}) // R4
    else $error("high area was banked");

  AST_ALL_OFF_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en && !bank_en) |=> to_fixed && phys_addr == {4'h0, $past(cpu_addr)}) // R12
    else $error("identity mapping broken");

  AST_NULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd4) |-> (phys_addr == 20'h0) && !to_fixed) // R10
    else $error("null region not clean");

  AST_WINDOW_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd1) |-> (phys_addr[19:16] == 4'h0)) // R1
    else $error("window left page 0");
endmodule

bind addr_xlat addr_xlat_checker u_xlat_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .win_en(win_en),
  .win_ofs(win_ofs), .bank_en(bank_en), .phys_addr(phys_addr),
  .region(region), .to_fixed(to_fixed)
);

// File: tb/test_addr_xlat.sv
`timescale 1ns/1ps
module test_addr_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        win_en, bank_en, bank_we;
  logic [7:0]  win_ofs, bank_wdata;
  logic [3:0]  bank_widx, ext_pages;
  logic [19:0] phys_addr;
  logic [2:0]  region;
  logic        to_fixed;

  int checks = 0;
  int errors = 0;
  logic [7:0] mb [16];

  always #2.5 clk = ~clk;

  addr_xlat i_addr_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .win_en(win_en), .win_ofs(win_ofs),
    .bank_en(bank_en), .bank_we(bank_we), .bank_widx(bank_widx), .bank_wdata(bank_wdata),
    .ext_pages(ext_pages), .phys_addr(phys_addr), .region(region), .to_fixed(to_fixed)
  );

  function automatic void model(input logic [15:0] a, output logic [19:0] p,
                                output logic [2:0] r, output logic f);
    logic [7:0] b;
    int pg;
    p = 20'h0; r = 3'd4; f = 1'b0;
    if (win_en && a >= 16'h7C00 && a <= 16'h7FFF) begin
      p = 20'((int'(win_ofs) * 256 + int'(a)) % 65536); r = 3'd1;
    end else if (bank_en && a < 16'hFC00) begin
      b = mb[a[15:12]];
      pg = int'(b) / 16;
      if (pg < 3) begin p = {b, a[11:0]}; r = 3'd2; end
      else if (pg == 3) begin
        if (!(b == 8'h3F && a[11:0] >= 12'hD80 && a[11:0] <= 12'hD97)) begin
          p = 20'(int'(b % 16) * 4096 + int'(a[11:0])); r = 3'd0; f = 1'b1;
        end
      end else if (pg < 4 + int'(ext_pages)) begin p = {b, a[11:0]}; r = 3'd3; end
    end else begin
      p = {4'h0, a}; r = 3'd0; f = 1'b1;
    end
  endfunction

  task automatic compare(input string tag, input logic [19:0] ep, input logic [2:0] er,
                         input logic ef);
    checks++;
    if (phys_addr !== ep || region !== er || to_fixed !== ef) begin
      errors++;
      $display("FAIL %s: got phys=%05h rgn=%0d fix=%0b expected phys=%05h rgn=%0d fix=%0b",
               tag, phys_addr, region, to_fixed, ep, er, ef);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] a, input logic we = 1'b0,
                      input logic [3:0] idx = 4'h0, input logic [7:0] val = 8'h00);
    logic [19:0] ep; logic [2:0] er; logic ef;
    cpu_addr = a; bank_we = we; bank_widx = idx; bank_wdata = val;
    model(a, ep, er, ef);
    @(posedge clk);
    @(negedge clk);
    bank_we = 1'b0;
    compare(tag, ep, er, ef);
    if (we) mb[idx] = val;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] val);
    step("R13 write", cpu_addr, 1'b1, idx, val);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0; win_en = 0; bank_en = 0; bank_we = 0;
    win_ofs = 8'h0; bank_widx = 4'h0; bank_wdata = 8'h0; ext_pages = 4'h0;
    for (int i = 0; i < 16; i++) mb[i] = 8'(8'h30 + i);
    repeat (3) @(negedge clk);
    compare("R11 reset outputs", 20'h0, 3'd4, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step("R12 all off", 16'h1234);
    step("R12 all off high", 16'hFFFE);
    bank_en = 1'b1;
    step("R11 identity bank", 16'h5123);
    step("R3 identity page A", 16'hA00F);
    // write and translate through the same register in one step
    step("R13 same-edge write uses old", 16'h2ABC, 1'b1, 4'h2, 8'h07);
    step("R8 low page", 16'h2ABC);
    wr(4'h5, 8'h3F);
    step("R6 hole low end", 16'h5D80);
    step("R6 hole high end", 16'h5D97);
    step("R7 above hole", 16'h5D98);
    step("R7 below hole", 16'h5D7F);
    wr(4'h6, 8'h3A);
    step("R5 standard redirect", 16'h6001);
    ext_pages = 4'd2;
    wr(4'h8, 8'h5C);
    step("R9 ext ram valid", 16'h8123);
    wr(4'h9, 8'h60);
    step("R10 ext beyond limit", 16'h9456);
    ext_pages = 4'd0;
    step("R10 no ext pages", 16'h8123);
    wr(4'hF, 8'h05);
    step("R4 fc00 bypass", 16'hFC00);
    step("R3 fbff banked", 16'hFBFF);
    win_en = 1'b1; win_ofs = 8'h12;
    wr(4'h7, 8'h05);
    step("R1 window base", 16'h7C00);
    step("R2 window over bank", 16'h7E01);
    step("R3 below window banked", 16'h7BFF);
    win_ofs = 8'hFF;
    step("R1 window wrap", 16'h7FFF);
    bank_en = 1'b0;
    step("R1 window only", 16'h7D00);

    for (int n = 0; n < 400; n++) begin
      win_en = 1'($urandom); bank_en = 1'($urandom % 4 != 0);
      win_ofs = 8'($urandom); ext_pages = 4'($urandom);
      step("R13 random", 16'($urandom), 1'($urandom % 3 == 0), 4'($urandom), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule